// File: doc/BRIEF.md
# Bus Master Transaction Sequencer

This block runs one transaction at a time on a shared system bus on behalf of a cache controller. When the controller presents a request, the sequencer raises a bus request and waits for a grant. It then drives the address and command and holds them until the addressed device accepts. For commands that carry a cache line, it moves the line as a separate data phase, one beat per target handshake. Other bus traffic may take place between the accepted command and the first data beat. After the final beat it releases the bus and pulses a completion signal that carries the transaction's tag.

While the request waits for the grant, the controller may withdraw it or change its fields. Once the grant has been taken, the transaction is fixed. The snoop path is independent of the sequencer's state. Every incoming snoop is acknowledged on the next cycle, so the owner of a pending request can always serve bus traffic (including flushing a line) and fetch deadlock is avoided. The acknowledgement also reports whether the snooped line matches the line of a request that is still waiting for the grant. Arbitration itself is outside the block.

Top module: `bus_txn_seq`

## Requirements
- R1: While reset is held, and in the first cycle after it, bus_req, bus_addr_valid, bus_data_valid, done, rd_valid and snp_ack are all low.
- R2: When req_valid is sampled high in idle, bus_req goes high in the next cycle and stays high, with no address phase, until a cycle in which bus_gnt is sampled high together with req_valid.
- R3: The cycle after the grant is taken, bus_addr_valid rises with bus_addr and bus_cmd equal to the latched request. These hold unchanged until bus_addr_ok is sampled. bus_req stays high through the address phase and is low from the cycle after it.
- R4: For data-carrying commands, bus_data_valid rises in the cycle after bus_addr_ok and stays high until BEATS beats have completed. A beat completes in each cycle in which bus_data_ok is high. After the last beat, all bus outputs return low.
- R5: Command codes on req_cmd and bus_cmd: 0 = read and 1 = read-for-ownership (both carry BEATS read beats, and rd_valid with rd_data = bus_rdata in each completing beat); 2 = upgrade (no data phase); 3 = write-back (carries BEATS write beats). For write-back, wr_beat gives the zero-based beat index and bus_wdata carries wr_data.
- R6: done is a single-cycle pulse, combinational with the completing handshake. It comes with the final data beat, or, for an upgrade, with the cycle bus_addr_ok is sampled. done_id carries the tag of the transaction.
- R7: If req_valid is low during a cycle in which bus_req is high and no address phase is active, the request is cancelled: bus_req is low in the next cycle, and no address phase and no done follow.
- R8: While waiting for the grant, including the grant cycle itself, req_addr, req_cmd and req_id are resampled every cycle. After the grant is taken, changes on all request inputs have no effect on bus_addr, bus_cmd or done_id.
- R9: snp_ack is high exactly in the cycle after each cycle with snp_valid high, in every sequencer state.
- R10: snp_conflict is high in the acknowledge cycle only if, when the snoop was sampled, the sequencer was waiting for the grant and snp_addr >> LINE_LSB equalled the pending request's address >> LINE_LSB.
- R11: A cancel takes priority over a grant sampled in the same cycle: bus_req drops and no address phase starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Cache controller has a pending request |
| req_cmd | input | 2 | Request command code |
| req_addr | input | ADDR_W | Request address |
| req_id | input | ID_W | Request tag |
| wr_data | input | DATA_W | Write-back data for the current beat |
| wr_beat | output | BEAT_W | Index of the current data beat |
| rd_valid | output | 1 | Read beat delivered this cycle |
| rd_data | output | DATA_W | Read beat data |
| done | output | 1 | Transaction complete pulse |
| done_id | output | ID_W | Tag of the completing transaction |
| snp_valid | input | 1 | Incoming snoop this cycle |
| snp_addr | input | ADDR_W | Snooped address |
| snp_ack | output | 1 | Snoop acknowledged |
| snp_conflict | output | 1 | Snoop hit the line of a request still waiting for the grant |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant |
| bus_addr_valid | output | 1 | Address and command phase active |
| bus_addr | output | ADDR_W | Bus address |
| bus_cmd | output | 2 | Bus command code |
| bus_addr_ok | input | 1 | Target accepts the command |
| bus_data_valid | output | 1 | Data phase active |
| bus_data_ok | input | 1 | Target completes a beat |
| bus_wdata | output | DATA_W | Write data on the bus |
| bus_rdata | input | DATA_W | Read data from the bus |

## Verification
The bound checker watches, on every cycle, the ordering of the handshakes. A request rises only after a pending request. An address phase starts only after a grant and holds stable until accepted. Data starts only after acceptance, and address and data never overlap. A cancel drops the request, snoops are always acknowledged in the next cycle, and done appears only on a completing handshake. Only the bench's scenarios can show the values and counts across a whole transaction: the exact completion cycle over a sweep of grant, accept and beat delays, and the beat count per command. They also show read and write payloads beat by beat, that the rewritten fields are the ones driven, that inputs changed after the grant are ignored, and that snoop conflict matching depends on the line address.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;

  typedef enum logic [1:0] {
    CMD_RD  = 2'd0,
    CMD_RDX = 2'd1,
    CMD_UPG = 2'd2,
    CMD_WB  = 2'd3
  } bus_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARB  = 2'd1,
    ST_ADDR = 2'd2,
    ST_DATA = 2'd3
  } seq_st_e;

  function automatic logic cmd_has_data(bus_cmd_e c);
    return c != CMD_UPG;
  endfunction

  function automatic logic cmd_is_write(bus_cmd_e c);
    return c == CMD_WB;
  endfunction

endpackage

// File: rtl/bus_seq_fsm.sv
module bus_seq_fsm
  import bus_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    req_valid,
  input  logic    gnt,
  input  logic    addr_ok,
  input  logic    data_ok,
  input  logic    has_data,
  input  logic    last_beat,
  output seq_st_e st,
  output logic    ev_grant,
  output logic    ev_cancel,
  output logic    ev_addr_acc,
  output logic    ev_beat,
  output logic    ev_final
);

  seq_st_e st_nx;

  // Named events; a cancel outranks a grant seen in the same cycle.
  always_comb begin
    ev_cancel   = (st == ST_ARB) && !req_valid;
    ev_grant    = (st == ST_ARB) && req_valid && gnt;
    ev_addr_acc = (st == ST_ADDR) && addr_ok;
    ev_beat     = (st == ST_DATA) && data_ok;
    ev_final    = (ev_addr_acc && !has_data) || (ev_beat && last_beat);
  end

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE: if (req_valid) st_nx = ST_ARB;
      ST_ARB: begin
        if (ev_cancel)     st_nx = ST_IDLE;
        else if (ev_grant) st_nx = ST_ADDR;
      end
      ST_ADDR: if (ev_addr_acc) st_nx = has_data ? ST_DATA : ST_IDLE;
      ST_DATA: if (ev_beat && last_beat) st_nx = ST_IDLE;
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_nx;
  end

endmodule

// File: rtl/bus_beat_ctr.sv
module bus_beat_ctr #(
  parameter int BEATS  = 4,
  parameter int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step,
  output logic [BEAT_W-1:0] cnt,
  output logic              last
);

  localparam logic [BEAT_W-1:0] LAST_IDX = BEAT_W'(BEATS - 1);

  assign last = (cnt == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) cnt <= '0;
    else if (step)       cnt <= last ? '0 : cnt + 1'b1;
  end

endmodule

// File: rtl/bus_snoop_port.sv
module bus_snoop_port #(
  parameter int ADDR_W   = 32,
  parameter int LINE_LSB = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              snp_valid,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic              pend_active,
  input  logic [ADDR_W-1:0] pend_addr,
  output logic              snp_ack,
  output logic              snp_conflict
);

  function automatic logic [ADDR_W-1:0] line_of(logic [ADDR_W-1:0] a);
    return a >> LINE_LSB;
  endfunction

  logic line_hit;
  assign line_hit = pend_active && (line_of(snp_addr) == line_of(pend_addr));

  // Independent of the sequencer: never stalls, always answers next cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snp_ack      <= 1'b0;
      snp_conflict <= 1'b0;
    end else begin
      snp_ack      <= snp_valid;
      snp_conflict <= snp_valid && line_hit;
    end
  end

endmodule

// File: rtl/bus_txn_seq.sv
module bus_txn_seq
  import bus_seq_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int ID_W     = 4,
  parameter int BEATS    = 4,
  parameter int LINE_LSB = 4,
  localparam int BEAT_W  = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_cmd,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ID_W-1:0]   req_id,
  input  logic [DATA_W-1:0] wr_data,
  output logic [BEAT_W-1:0] wr_beat,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              done,
  output logic [ID_W-1:0]   done_id,
  input  logic              snp_valid,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_ack,
  output logic              snp_conflict,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              bus_addr_valid,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        bus_cmd,
  input  logic              bus_addr_ok,
  output logic              bus_data_valid,
  input  logic              bus_data_ok,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata
);

  seq_st_e           st;
  logic              ev_grant, ev_cancel, ev_addr_acc, ev_beat, ev_final;
  logic              beat_last;
  logic              latch_en;
  logic              waiting;
  bus_cmd_e          pend_cmd;
  logic [ADDR_W-1:0] pend_addr;
  logic [ID_W-1:0]   pend_id;

  assign waiting  = (st == ST_ARB);
  // Fields follow the inputs until the grant edge, then freeze.
  assign latch_en = req_valid && ((st == ST_IDLE) || waiting);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_cmd  <= CMD_RD;
      pend_addr <= '0;
      pend_id   <= '0;
    end else if (latch_en) begin
      pend_cmd  <= bus_cmd_e'(req_cmd);
      pend_addr <= req_addr;
      pend_id   <= req_id;
    end
  end

  bus_seq_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .gnt         (bus_gnt),
    .addr_ok     (bus_addr_ok),
    .data_ok     (bus_data_ok),
    .has_data    (cmd_has_data(pend_cmd)),
    .last_beat   (beat_last),
    .st          (st),
    .ev_grant    (ev_grant),
    .ev_cancel   (ev_cancel),
    .ev_addr_acc (ev_addr_acc),
    .ev_beat     (ev_beat),
    .ev_final    (ev_final)
  );

  bus_beat_ctr #(.BEATS(BEATS), .BEAT_W(BEAT_W)) u_beats (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (ev_addr_acc),
    .step  (ev_beat),
    .cnt   (wr_beat),
    .last  (beat_last)
  );

  bus_snoop_port #(.ADDR_W(ADDR_W), .LINE_LSB(LINE_LSB)) u_snoop (
    .clk          (clk),
    .rst_n        (rst_n),
    .snp_valid    (snp_valid),
    .snp_addr     (snp_addr),
    .pend_active  (waiting),
    .pend_addr    (pend_addr),
    .snp_ack      (snp_ack),
    .snp_conflict (snp_conflict)
  );

  // Bus side: request spans arbitration and the address phase.
  assign bus_req        = waiting || (st == ST_ADDR);
  assign bus_addr_valid = (st == ST_ADDR);
  assign bus_data_valid = (st == ST_DATA);
  assign bus_addr       = pend_addr;
  assign bus_cmd        = pend_cmd;
  assign bus_wdata      = (bus_data_valid && cmd_is_write(pend_cmd)) ? wr_data : '0;

  // Cache side.
  assign rd_valid = ev_beat && !cmd_is_write(pend_cmd);
  assign rd_data  = bus_rdata;
  assign done     = ev_final;
  assign done_id  = pend_id;

endmodule

// File: rtl/bus_txn_seq_chk.sv
module bus_txn_seq_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              bus_req,
  input logic              bus_gnt,
  input logic              bus_addr_valid,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [1:0]        bus_cmd,
  input logic              bus_addr_ok,
  input logic              bus_data_valid,
  input logic              bus_data_ok,
  input logic              done,
  input logic              snp_valid,
  input logic              snp_ack,
  input logic              snp_conflict
);

  a_r2_req_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> $past(req_valid));

  a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_addr_valid && req_valid && !bus_gnt) |=> (bus_req && !bus_addr_valid));

  a_r3_addr_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_addr_valid) |-> $past(bus_gnt && bus_req));

  a_r3_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr_valid && !bus_addr_ok) |=> (bus_addr_valid && $stable(bus_addr) && $stable(bus_cmd)));

  a_r3_req_during_addr: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr_valid |-> bus_req);

  a_r4_data_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_data_valid) |-> $past(bus_addr_valid && bus_addr_ok));

  a_r4_phases_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bus_addr_valid, bus_data_valid}) && !(bus_data_valid && bus_req));

  a_r6_done_on_handshake: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((bus_data_valid && bus_data_ok) ||
              (bus_addr_valid && bus_addr_ok && bus_cmd == 2'd2)));

  a_r7_cancel_drops_req: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_addr_valid && !req_valid) |=> !bus_req);

  a_r9_snoop_ack: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |=> snp_ack);

  a_r9_no_spurious_ack: assert property (@(posedge clk) disable iff (!rst_n)
    !snp_valid |=> !snp_ack);

  a_r10_conflict_only_waiting: assert property (@(posedge clk) disable iff (!rst_n)
    snp_conflict |-> $past(bus_req && !bus_addr_valid && snp_valid));

endmodule

bind bus_txn_seq bus_txn_seq_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/bus_txn_seq_tb.sv
module bus_txn_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32, DATA_W = 32, ID_W = 4, BEATS = 4, LINE_LSB = 4;
  localparam int BEAT_W = 2;

  logic clk = 1'b0, rst_n;
  logic req_valid; logic [1:0] req_cmd; logic [ADDR_W-1:0] req_addr; logic [ID_W-1:0] req_id;
  logic [DATA_W-1:0] wr_data; logic [BEAT_W-1:0] wr_beat;
  logic rd_valid; logic [DATA_W-1:0] rd_data; logic done; logic [ID_W-1:0] done_id;
  logic snp_valid; logic [ADDR_W-1:0] snp_addr; logic snp_ack, snp_conflict;
  logic bus_req, bus_gnt, bus_addr_valid, bus_addr_ok, bus_data_valid, bus_data_ok;
  logic [ADDR_W-1:0] bus_addr; logic [1:0] bus_cmd;
  logic [DATA_W-1:0] bus_wdata, bus_rdata;

  int errs = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_txn_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W), .BEATS(BEATS), .LINE_LSB(LINE_LSB)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd), .req_addr(req_addr),
    .req_id(req_id), .wr_data(wr_data), .wr_beat(wr_beat), .rd_valid(rd_valid), .rd_data(rd_data),
    .done(done), .done_id(done_id), .snp_valid(snp_valid), .snp_addr(snp_addr), .snp_ack(snp_ack),
    .snp_conflict(snp_conflict), .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_addr_valid(bus_addr_valid),
    .bus_addr(bus_addr), .bus_cmd(bus_cmd), .bus_addr_ok(bus_addr_ok), .bus_data_valid(bus_data_valid),
    .bus_data_ok(bus_data_ok), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  function automatic logic [DATA_W-1:0] rpat(logic [ADDR_W-1:0] a, int b);
    return a ^ (32'h0101_0000 * (b + 1));
  endfunction

  function automatic logic [DATA_W-1:0] wpat(logic [ADDR_W-1:0] a, int b);
    return ~a + 32'(b * 7);
  endfunction

  task automatic idle_inputs();
    req_valid = 0; req_cmd = 0; req_addr = '0; req_id = '0; wr_data = '0;
    snp_valid = 0; snp_addr = '0; bus_gnt = 0; bus_addr_ok = 0; bus_data_ok = 0; bus_rdata = '0;
  endtask

  // One transaction: gd/ad/dg are grant, accept and per-beat delays.
  // Fields are rewritten once while waiting (R8) and trashed after the grant.
  task automatic run_txn(input logic [1:0] cmd, input logic [ID_W-1:0] id1, input logic [ADDR_W-1:0] a1,
                         input logic [ID_W-1:0] id2, input logic [ADDR_W-1:0] a2,
                         input int gd, input int ad, input int dg);
    int wc = 0, ac = 0, dc = 0, beats = 0, done_cnt = 0, done_n = -1;
    int exp_beats = (cmd == 2'd2) ? 0 : BEATS;
    int exp_n = 2 + gd + ad + exp_beats * (dg + 1);
    logic [ID_W-1:0] got_id = '0;
    bit prev_snp = 0;
    @(negedge clk);
    req_valid = 1; req_cmd = cmd; req_id = id1; req_addr = a1;
    for (int n = 1; n <= exp_n + 1; n++) begin
      @(negedge clk);
      bus_gnt = 0; bus_addr_ok = 0; bus_data_ok = 0;
      if (n == 1) begin
        chk(bus_req && !bus_addr_valid, "R2", "request raised after issue", bus_req, 1);
        req_id = id2; req_addr = a2;
      end
      if (bus_req && !bus_addr_valid) begin
        bus_gnt = (wc == gd); wc++;
      end
      if (bus_addr_valid) begin
        chk(bus_addr == a2 && bus_cmd == cmd, "R3", "address/command driven", {bus_cmd, bus_addr}, {cmd, a2});
        req_valid = 0; req_addr = ~a2; req_id = ~id2; req_cmd = ~cmd;
        bus_addr_ok = (ac == ad); ac++;
      end
      if (bus_data_valid) begin
        bus_data_ok = (dc == dg);
        dc = (dc == dg) ? 0 : dc + 1;
        wr_data = wpat(a2, int'(wr_beat));
      end
      bus_rdata = rpat(a2, beats);
      snp_valid = n[0]; snp_addr = 32'hFFFF_FFF0;
      #1;
      if (n > 1) chk(snp_ack == prev_snp && !snp_conflict, "R9", "snoop ack while busy", snp_ack, prev_snp);
      prev_snp = snp_valid;
      if (bus_data_valid && bus_data_ok) begin
        if (cmd == 2'd3)
          chk(bus_wdata == wpat(a2, beats) && !rd_valid, "R5", "write beat data", bus_wdata, wpat(a2, beats));
        else
          chk(rd_valid && rd_data == rpat(a2, beats), "R5", "read beat data", rd_data, rpat(a2, beats));
        beats++;
      end
      if (done) begin done_cnt++; done_n = n; got_id = done_id; end
      if (n == exp_n + 1)
        chk(!bus_req && !bus_addr_valid && !bus_data_valid, "R4", "bus released after final beat",
            {bus_req, bus_addr_valid, bus_data_valid}, 0);
    end
    chk(beats == exp_beats, "R4", "beat count", beats, exp_beats);
    chk(done_cnt == 1 && done_n == exp_n, "R6", "done timing", done_n, exp_n);
    chk(got_id == id2, "R8", "done_id is rewritten tag, later changes ignored", got_id, id2);
    idle_inputs();
  endtask

  task automatic cancel_test(input bit grant_same);
    @(negedge clk);
    req_valid = 1; req_cmd = 2'd0; req_addr = 32'h0000_5A00; req_id = 4'h9;
    @(negedge clk);
    chk(bus_req, "R7", "request raised before cancel", bus_req, 1);
    req_valid = 0; bus_gnt = grant_same;
    @(negedge clk);
    bus_gnt = 0;
    chk(!bus_req && !bus_addr_valid, grant_same ? "R11" : "R7", "request dropped after cancel",
        {bus_req, bus_addr_valid}, 0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); #1;
      chk(!done && !bus_addr_valid && !bus_req, "R7", "no activity after cancel",
          {done, bus_addr_valid, bus_req}, 0);
    end
    idle_inputs();
  endtask

  task automatic snoop_test();
    logic [ADDR_W-1:0] x = 32'h0000_7740;
    @(negedge clk);
    snp_valid = 1; snp_addr = x;
    @(negedge clk);
    snp_valid = 0;
    chk(snp_ack && !snp_conflict, "R10", "idle snoop: ack without conflict", {snp_ack, snp_conflict}, 2'b10);
    @(negedge clk);
    chk(!snp_ack, "R9", "no ack without snoop", snp_ack, 0);
    req_valid = 1; req_cmd = 2'd1; req_addr = x; req_id = 4'h3;
    @(negedge clk);
    snp_valid = 1; snp_addr = x + 32'd9;
    @(negedge clk);
    chk(snp_ack && snp_conflict, "R10", "same-line snoop while waiting", {snp_ack, snp_conflict}, 2'b11);
    snp_addr = x + 32'd16;
    @(negedge clk);
    chk(snp_ack && !snp_conflict, "R10", "other-line snoop while waiting", {snp_ack, snp_conflict}, 2'b10);
    snp_valid = 0; req_valid = 0;
    @(negedge clk);
    chk(!bus_req, "R7", "cancel after snoop", bus_req, 0);
    idle_inputs();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; errs++;
    $display("FAIL watchdog: run did not finish");
    report();
  end

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk(!bus_req && !bus_addr_valid && !bus_data_valid && !done && !rd_valid && !snp_ack, "R1",
        "outputs quiet in reset", {bus_req, bus_addr_valid, bus_data_valid, done, rd_valid, snp_ack}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!bus_req && !bus_addr_valid && !bus_data_valid && !done, "R1", "outputs quiet after reset",
        {bus_req, bus_addr_valid, bus_data_valid, done}, 0);
    for (int c = 0; c < 4; c++)
      for (int g = 0; g < 3; g++)
        for (int a = 0; a < 3; a++)
          for (int d = 0; d < 2; d++)
            run_txn(2'(c), 4'(c * 3 + g), 32'h1000_0000 + 32'(c * 256 + g * 64),
                    4'(15 - c - a), 32'h2000_0000 + 32'(c * 512 + a * 32 + d * 4), g, a, d);
    cancel_test(1'b0);
    cancel_test(1'b1);
    snoop_test();
    run_txn(2'd3, 4'hA, 32'h3000_0000, 4'h5, 32'h3000_0100, 4, 2, 3);
    report();
  end
endmodule